// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write-side command decoder of a parallel NOR flash model that follows the common unlock-cycle command set. Each bus write, a byte address plus a data byte, advances a small state machine. It checks the two-cycle unlock handshake, then decodes a command byte that arms a byte program, starts a chip or sector erase, opens the identification (autoselect) view, or enables a bypass mode in which programs skip the unlock handshake. It also recognises the query-table entry write.

The block owns the storage array. Programming ANDs data into a byte, so bits can only go from 1 to 0. Erasing fills the chip or one sector with 0xFF in a single cycle, and a busy window of a set number of cycles follows. A companion read-path block uses the `mode` output to choose between array data, identification words, the status byte and the query table. It reads the array through the `rd_addr`/`rd_data` port.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to the array-read state with bypass cleared. After that edge `mode` is 0, `busy` is 0 and `status` is 0x00. The array is not touched.
- R2: Commands are taken only after 0xAA at word offset UNLOCK0 and then 0x55 at word offset UNLOCK1, followed by a command write at UNLOCK0. A wrong address or wrong data in any of these cycles returns the sequencer to the read state.
- R3: After command 0xA0 the next write programs the byte at its address to old AND new. A second program of the same byte can only clear more bits.
- R4: Command 0x90 selects the identification view (`mode` = 1). The next write of any other kind returns to `mode` = 0.
- R5: A write of 0x98 at word offset 0x55 enters the query view (`mode` = 3) from the read state or from the identification view. Any write in the query view returns to `mode` = 0.
- R6: A write of 0xF0 at any address returns to the read state and clears bypass. While a program is armed, 0xF0 is instead stored as program data.
- R7: The erase sequence is unlock, 0x80, unlock, then 0x10 at UNLOCK0. It sets every byte to 0xFF, clears `status` to 0x00 and holds `busy` high for exactly CHIP_ERASE_CYC cycles.
- R8: The same sequence ending in 0x30 erases only the sector that holds the write address, for SECT_ERASE_CYC cycles. Other sectors keep their contents.
- R9: While `busy` is high every write is ignored, 0xF0 included. `mode` stays 2 and the array and `status` stay unchanged.
- R10: When the busy window ends, `status` bit 7 inverts. The sequencer returns to the command cycle if bypass is on, otherwise to the read state.
- R11: Command 0x20 turns bypass on. In bypass, 0xA0 at any address followed by a data write programs, and this repeats without any unlock cycles.
- R12: In bypass, 0x90 followed by 0x00 leaves bypass and returns to the read state. After that a lone 0xA0 no longer arms a program.
- R13: While a program is armed and while an erase is busy, `mode` is 2 (status view). A program sets `status` to 0x7F when data bit 7 is 1 and to 0xFF when it is 0.
- R14: Any command byte other than 0x20, 0x80, 0x90 and 0xA0 in the command cycle returns to the read state and clears bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data / command byte |
| rd_addr | input | ADDR_W | Array read address from the read path |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| mode | output | 2 | 0 array, 1 identification, 2 status, 3 query |
| status | output | 8 | Status byte for the read path |
| busy | output | 1 | Erase in progress |

## Verification
On every cycle the assertions check the following. The reset state is correct. `busy` implies the status view, and `status` is frozen while busy. An erase start clears the status. The end of busy flips status bit 7. Any write in the query view leaves that view. The scenarios have to show the things that depend on whole write sequences and on array contents. These are the AND-only programming, the single-sector erase with its neighbours untouched, the exact busy lengths, the bypass entry and exit, and the rejection of broken unlocks or unknown commands, all checked through the read port.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int ADDR_W         = 9,
  parameter int SECT_BYTES     = 128,
  parameter int DEV_BYTES      = 1,
  parameter int UNLOCK0        = 'h55,
  parameter int UNLOCK1        = 'h2A,
  parameter int CFI_OFF        = 'h55,
  parameter int CHIP_ERASE_CYC = 200,
  parameter int SECT_ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [1:0]        mode,
  output logic [7:0]        status,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SECT_W = $clog2(SECT_BYTES);
  localparam int SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  localparam int OFF_W = SECT_W - SHIFT;
  localparam int CNT_W = $clog2(CHIP_ERASE_CYC + 1);
  localparam logic [OFF_W-1:0] U0 = OFF_W'(UNLOCK0);
  localparam logic [OFF_W-1:0] U1 = OFF_W'(UNLOCK1);
  localparam logic [OFF_W-1:0] QO = OFF_W'(CFI_OFF);

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_PROG, ST_EUNL0, ST_EUNL1, ST_ECMD,
    ST_BUSY, ST_AUTO, ST_QRY
  } st_t;

  st_t              st, nst;
  logic             bypass, nbyp;
  logic             do_prog, do_chip, do_sect;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       mem [DEPTH];

  wire [SECT_W-1:0] sect_off = wr_addr[SECT_W-1:0];
  wire [OFF_W-1:0]  off = OFF_W'(sect_off >> SHIFT);
  wire [7:0]        d = wr_data;

  assign rd_data = mem[rd_addr];
  assign busy    = (st == ST_BUSY);
  assign mode    = (st == ST_AUTO) ? 2'd1 :
                   (st == ST_QRY)  ? 2'd3 :
                   (st == ST_PROG || st == ST_BUSY) ? 2'd2 : 2'd0;

  always_comb begin
    nst = st;
    nbyp = bypass;
    do_prog = 1'b0;
    do_chip = 1'b0;
    do_sect = 1'b0;
    if (wr_en && st != ST_BUSY) begin
      if (d == 8'hF0 && st != ST_PROG) begin
        nst = ST_READ;
        nbyp = 1'b0;
      end else begin
        nst = ST_READ;
        nbyp = 1'b0;
        case (st)
          ST_READ:
            if (off == QO && d == 8'h98) nst = ST_QRY;
            else if (off == U0 && d == 8'hAA) nst = ST_UNL1;
          ST_UNL1:
            if (off == U1 && d == 8'h55) nst = ST_CMD;
          ST_CMD:
            if (bypass || off == U0) begin
              nbyp = bypass;
              case (d)
                8'h20: begin nst = ST_CMD; nbyp = 1'b1; end
                8'h80: nst = ST_EUNL0;
                8'h90: nst = ST_AUTO;
                8'hA0: nst = ST_PROG;
                default: begin nst = ST_READ; nbyp = 1'b0; end
              endcase
            end
          ST_PROG: begin
            do_prog = 1'b1;
            nbyp = bypass;
            nst = bypass ? ST_CMD : ST_READ;
          end
          ST_EUNL0:
            if (off == U0 && d == 8'hAA) begin nst = ST_EUNL1; nbyp = bypass; end
          ST_EUNL1:
            if (off == U1 && d == 8'h55) begin nst = ST_ECMD; nbyp = bypass; end
          ST_ECMD:
            if (d == 8'h10 && off == U0) begin
              do_chip = 1'b1; nst = ST_BUSY; nbyp = bypass;
            end else if (d == 8'h30) begin
              do_sect = 1'b1; nst = ST_BUSY; nbyp = bypass;
            end
          ST_AUTO:
            if (off == QO && d == 8'h98) nst = ST_QRY;
          default: nst = ST_READ;
        endcase
      end
    end else if (st == ST_BUSY && cnt == '0) begin
      nst = bypass ? ST_CMD : ST_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_READ;
      bypass <= 1'b0;
      status <= 8'h00;
      cnt <= '0;
    end else begin
      st <= nst;
      bypass <= nbyp;
      if (do_prog) begin
        status <= {~d[7], 7'h7F};
      end else if (do_chip) begin
        status <= 8'h00;
        cnt <= CNT_W'(CHIP_ERASE_CYC - 1);
      end else if (do_sect) begin
        status <= 8'h00;
        cnt <= CNT_W'(SECT_ERASE_CYC - 1);
      end else if (st == ST_BUSY) begin
        if (cnt == '0) status[7] <= ~status[7];
        else cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_chip || (do_sect && ADDR_W'(i) >> SECT_W == wr_addr >> SECT_W))
        mem[i] <= 8'hFF;
      else if (do_prog && ADDR_W'(i) == wr_addr)
        mem[i] <= mem[i] & d;
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] mode,
  input logic [7:0] status,
  input logic       busy
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    rst_q <= rst;
    if (rst_q)
      a_r1_reset_state: assert (mode == 2'd0 && !busy && status == 8'h00);
  end

  a_r9_busy_status_view: assert property (@(posedge clk) disable iff (rst)
    busy |-> mode == 2'd2);

  a_r9_status_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(status));

  a_r7_erase_clears_status: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !$past(rst)) |-> status == 8'h00);

  a_r10_end_flips_bit7: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> status[7] != $past(status[7]));

  a_r5_query_exit: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && wr_en) |=> mode == 2'd0);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .mode(mode), .status(status), .busy(busy)
);

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;
  localparam int AW = 9;
  localparam int CHIP_N = 60;
  localparam int SECT_N = 6;
  localparam logic [AW-1:0] A0 = 9'h055;
  localparam logic [AW-1:0] A1 = 9'h02A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] mode;
  logic [7:0] status;
  logic busy;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .SECT_BYTES(128), .CHIP_ERASE_CYC(CHIP_N),
                .SECT_ERASE_CYC(SECT_N)) i_nor_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode), .status(status), .busy(busy));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(A0, 8'hAA);
    wr(A1, 8'h55);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
    @(negedge clk);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 status", status, 8'h00);
  endtask

  task automatic t_chip_erase();
    int n; logic [7:0] v;
    unlock(); wr(A0, 8'h80); unlock(); wr(A0, 8'h10);
    chk("R7 busy", busy, 1);
    chk("R7 status cleared", status, 8'h00);
    chk("R13 mode while busy", mode, 2);
    wait_busy(n);
    chk("R7 busy length", n, CHIP_N);
    chk("R10 bit7 flipped", status, 8'h80);
    chk("R10 back to read", mode, 0);
    rd(9'h000, v); chk("R7 byte 0", v, 8'hFF);
    rd(9'h0C3, v); chk("R7 byte C3", v, 8'hFF);
    rd(9'h1FF, v); chk("R7 byte 1FF", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    unlock(); wr(A0, 8'hA0);
    chk("R13 armed mode", mode, 2);
    wr(9'h010, 8'h5A);
    rd(9'h010, v); chk("R2 program", v, 8'h5A);
    chk("R13 status d7=0", status, 8'hFF);
    chk("R2 mode after program", mode, 0);
    unlock(); wr(A0, 8'hA0); wr(9'h010, 8'h0F);
    rd(9'h010, v); chk("R3 and-only", v, 8'h0A);
    unlock(); wr(A0, 8'hA0); wr(9'h011, 8'h80);
    chk("R13 status d7=1", status, 8'h7F);
  endtask

  task automatic t_bad_unlock();
    logic [7:0] v;
    wr(A0, 8'hAA); wr(A1, 8'h56); wr(A0, 8'hA0); wr(9'h020, 8'h00);
    rd(9'h020, v); chk("R2 bad data cycle2", v, 8'hFF);
    unlock(); wr(9'h010, 8'hA0); wr(9'h021, 8'h00);
    rd(9'h021, v); chk("R2 bad cmd address", v, 8'hFF);
    chk("R2 mode", mode, 0);
  endtask

  task automatic t_autoselect();
    unlock(); wr(A0, 8'h90);
    chk("R4 enter", mode, 1);
    wr(9'h003, 8'h12);
    chk("R4 leave", mode, 0);
  endtask

  task automatic t_query();
    wr(9'h055, 8'h98);
    chk("R5 from read", mode, 3);
    wr(9'h000, 8'h00);
    chk("R5 exit", mode, 0);
    unlock(); wr(A0, 8'h90); wr(9'h055, 8'h98);
    chk("R5 from autoselect", mode, 3);
    wr(9'h007, 8'hF0);
    chk("R6 F0 leaves query", mode, 0);
  endtask

  task automatic t_reset_cmd();
    logic [7:0] v;
    unlock(); wr(A0, 8'hA0); wr(9'h012, 8'hF0);
    rd(9'h012, v); chk("R6 F0 programmed when armed", v, 8'hF0);
    unlock(); wr(A0, 8'h90); wr(9'h1F0, 8'hF0);
    chk("R6 F0 from autoselect", mode, 0);
  endtask

  task automatic t_sector_erase();
    int n; logic [7:0] v;
    unlock(); wr(A0, 8'hA0); wr(9'h085, 8'h00);
    unlock(); wr(A0, 8'hA0); wr(9'h005, 8'h00);
    unlock(); wr(A0, 8'h80); unlock(); wr(9'h090, 8'h30);
    chk("R8 busy", busy, 1);
    wr(9'h000, 8'hF0);
    wr(A0, 8'hAA);
    chk("R9 still busy", busy, 1);
    chk("R9 mode", mode, 2);
    chk("R9 status held", status, 8'h00);
    wait_busy(n);
    chk("R8 busy length", n, SECT_N - 2);
    chk("R10 status", status, 8'h80);
    rd(9'h085, v); chk("R8 target sector", v, 8'hFF);
    rd(9'h005, v); chk("R8 other sector", v, 8'h00);
    rd(9'h010, v); chk("R8 other sector 2", v, 8'h0A);
  endtask

  task automatic t_bypass();
    int n; logic [7:0] v;
    unlock(); wr(A0, 8'h20);
    chk("R11 mode", mode, 0);
    wr(9'h007, 8'hA0); wr(9'h140, 8'h33);
    rd(9'h140, v); chk("R11 first", v, 8'h33);
    wr(9'h000, 8'hA0); wr(9'h141, 8'h30);
    rd(9'h141, v); chk("R11 second", v, 8'h30);
    wr(9'h000, 8'h80); unlock(); wr(9'h180, 8'h30);
    wait_busy(n);
    chk("R10 bypass sector len", n, SECT_N);
    wr(9'h001, 8'hA0); wr(9'h181, 8'h11);
    rd(9'h181, v); chk("R10 back to command cycle", v, 8'h11);
  endtask

  task automatic t_bypass_exit();
    logic [7:0] v;
    wr(9'h000, 8'h90);
    chk("R12 autoselect in bypass", mode, 1);
    wr(9'h000, 8'h00);
    chk("R12 mode", mode, 0);
    wr(9'h003, 8'hA0); wr(9'h042, 8'h00);
    rd(9'h042, v); chk("R12 no program", v, 8'hFF);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] v;
    unlock(); wr(A0, 8'h20);
    wr(9'h000, 8'h77);
    wr(9'h000, 8'hA0); wr(9'h043, 8'h00);
    rd(9'h043, v); chk("R14 bypass cleared", v, 8'hFF);
    unlock(); wr(A0, 8'h20); wr(9'h000, 8'hF0);
    wr(9'h000, 8'hA0); wr(9'h044, 8'h00);
    rd(9'h044, v); chk("R6 F0 clears bypass", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_chip_erase();
    t_program();
    t_bad_unlock();
    t_autoselect();
    t_query();
    t_reset_cmd();
    t_sector_erase();
    t_bypass();
    t_bypass_exit();
    t_bad_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule